// File: doc/BRIEF.md
# Configurable asynchronous serial transceiver

This block pairs a transmitter and a receiver for framed asynchronous serial characters. A small set of mode inputs selects whether a parity bit is sent and checked, the parity sense, one or two stop bits, and a multiprocessor variant. In that variant an address/data marker bit takes the place of the parity bit. The transmitter accepts a character over a valid/ready handshake and shifts it out on a line that idles high. The receiver samples its input against an enable tick at sixteen times the bit rate. It presents each character together with its multiprocessor marker and its parity, framing and overrun flags until they are read.

The baud-rate generator is not part of the block. It supplies only the `tick` enable, and one bit lasts sixteen ticks. Both directions capture the mode inputs when a character begins, so software may change the mode at any time without corrupting a character already in flight.

Top module: `async_serial_xcvr`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: A character accepted on a cycle with `tx_valid` and `tx_ready` both high is sent as follows: a 0 start bit, the 8 data bits least significant first, an optional extra bit, then the stop bits at 1. Each bit lasts 16 ticks. `tx_ready` stays low from acceptance until the last stop bit has been sent.
- R3: When `cfg_par_en`=1 and `cfg_mp_mode`=0, a parity bit follows the data. When `cfg_par_odd`=0 the data ones plus the parity bit total an even count, and when `cfg_par_odd`=1 they total an odd count. With `cfg_par_en`=0 no extra bit is sent.
- R4: When parity is enabled, the receiver counts the ones in the received data plus the received parity bit. It sets `rx_par_err` with the character when the count's sense does not match `cfg_par_odd`.
- R5: `cfg_two_stop`=0 makes the transmitter send one stop bit, and `cfg_two_stop`=1 makes it send two.
- R6: The receiver checks only the first stop bit and sets `rx_frm_err` when that bit samples 0. A 0 where a second stop bit would be is taken as the start bit of the next character.
- R7: With `cfg_mp_mode`=1, `cfg_par_en` and `cfg_par_odd` have no effect. The extra bit sent is `tx_mpb`, the received extra bit appears on `rx_mpb`, and `rx_par_err` stays 0. Outside this mode `rx_mpb` is 0.
- R8: A falling edge on `rxd` begins a character only if the line is still 0 at the sample taken 8 ticks later. A shorter low pulse yields no character. Later bits are sampled every 16 ticks.
- R9: When a character completes while `rx_valid` is still high and `rx_read` is low, `rx_ovr_err` is set and the new character replaces the old.
- R10: A change of any mode input while a character is in flight does not alter that character's format or length.
- R11: `rx_valid` stays high until a cycle with `rx_read` high. It then clears on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable at 16x the bit rate |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | 0 even, 1 odd parity |
| cfg_two_stop | input | 1 | 0 one stop bit, 1 two stop bits (transmit) |
| cfg_mp_mode | input | 1 | Multiprocessor marker replaces parity |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| tx_data | input | 8 | Character to send |
| tx_mpb | input | 1 | Marker bit to send in multiprocessor mode |
| txd | output | 1 | Serial output, high when idle |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_valid | output | 1 | Received character available |
| rx_read | input | 1 | Consumer takes the received character |
| rx_data | output | 8 | Received character |
| rx_mpb | output | 1 | Received marker bit |
| rx_par_err | output | 1 | Parity error for this character |
| rx_frm_err | output | 1 | First stop bit sampled low |
| rx_ovr_err | output | 1 | Previous character was overwritten unread |

## Verification
The bench samples the serial output at bit centres to check bit order and the parity value in both senses. It also times `tx_ready`, which exposes a stop-count error or a frame cut short. It changes the mode in the middle of a frame: a design that does not latch the mode would lengthen or reshape that frame. On the receive side it drives a wrong parity bit, a low first stop bit, and a character whose second stop position is already the next start bit. A receiver that checked both stop bits would lose or flag that second character. A short low glitch must produce nothing, while a receiver that skipped start confirmation would deliver garbage. Two unread characters must raise overrun, and the multiprocessor marker must come through while parity checking is suppressed.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef struct packed {
      logic par_en;
      logic par_odd;
      logic two_stop;
      logic mp_mode;
   } frame_cfg_t;

   // an extra bit follows the data when parity or the marker is in use
   function automatic logic has_extra(frame_cfg_t c);
      return c.mp_mode | c.par_en;
   endfunction

endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   initial begin
      assert (STAGES >= 0 && STAGES <= 4) else $error("xcvr_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2+((STAGES==1)?1:0):0], din} ;
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/xcvr_tx.sv
module xcvr_tx
   import xcvr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  frame_cfg_t        cfg,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_mpb,
   output logic              txd
);

   localparam int FW = DATA_W + 4;
   localparam int CW = $clog2(OVS);
   localparam int NW = $clog2(FW + 1);

   initial begin
      assert (OVS >= 4 && (OVS % 2) == 0) else $error("xcvr_tx: OVS must be even and >= 4");
      assert (DATA_W >= 5) else $error("xcvr_tx: DATA_W too small");
   end

   logic          busy;
   logic [FW-1:0] shreg;
   logic [NW-1:0] nleft;
   logic [CW-1:0] tcnt;

   logic          extra_bit;
   logic [FW-1:0] frame;
   logic [NW-1:0] nbits;

   always_comb begin
      extra_bit = cfg.mp_mode ? tx_mpb : ((^tx_data) ^ cfg.par_odd);
      frame = '1;
      frame[0] = 1'b0;
      frame[DATA_W:1] = tx_data;
      if (has_extra(cfg)) frame[DATA_W+1] = extra_bit;
      nbits = NW'(DATA_W + 2) + NW'(has_extra(cfg)) + NW'(cfg.two_stop);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         shreg <= '1;
         nleft <= '0;
         tcnt  <= '0;
      end else if (!busy) begin
         if (tx_valid) begin
            busy  <= 1'b1;
            shreg <= frame;
            nleft <= nbits;
            tcnt  <= '0;
         end
      end else if (tick) begin
         if (tcnt == CW'(OVS - 1)) begin
            tcnt  <= '0;
            shreg <= {1'b1, shreg[FW-1:1]};
            nleft <= nleft - 1'b1;
            if (nleft == NW'(1)) busy <= 1'b0;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   assign tx_ready = !busy;
   assign txd      = busy ? shreg[0] : 1'b1;

   a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> (!tx_ready && !txd));

   a_r2_busy_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_ready && !tick) |=> !tx_ready);

   a_r10_line_steady_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_ready && !tick) |=> $stable(txd));

endmodule

// File: rtl/xcvr_rx.sv
module xcvr_rx
   import xcvr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  frame_cfg_t        cfg,
   input  logic              rxs,
   input  logic              rx_read,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_mpb,
   output logic              rx_par_err,
   output logic              rx_frm_err,
   output logic              rx_ovr_err
);

   localparam int CW   = $clog2(OVS);
   localparam int BW   = $clog2(DATA_W);
   localparam int HALF = OVS / 2;

   initial begin
      assert (OVS >= 4 && (OVS % 2) == 0) else $error("xcvr_rx: OVS must be even and >= 4");
   end

   typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_EXTRA, R_STOP} rx_state_t;

   rx_state_t         st;
   logic [CW-1:0]     tcnt;
   logic [BW-1:0]     bidx;
   logic [DATA_W-1:0] shreg;
   logic              xbit;
   frame_cfg_t        cfg_q;

   logic full_bit;
   logic done;

   assign full_bit = tick && (tcnt == CW'(OVS - 1));
   assign done     = full_bit && (st == R_STOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= R_IDLE;
         tcnt  <= '0;
         bidx  <= '0;
         shreg <= '0;
         xbit  <= 1'b0;
         cfg_q <= '0;
      end else if (tick) begin
         unique case (st)
            R_IDLE: begin
               if (!rxs) begin
                  st    <= R_START;
                  tcnt  <= '0;
                  cfg_q <= cfg;
               end
            end
            R_START: begin
               if (tcnt == CW'(HALF - 1)) begin
                  tcnt <= '0;
                  bidx <= '0;
                  st   <= rxs ? R_IDLE : R_DATA;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            R_DATA: begin
               if (full_bit) begin
                  tcnt  <= '0;
                  shreg <= {rxs, shreg[DATA_W-1:1]};
                  if (bidx == BW'(DATA_W - 1))
                     st <= has_extra(cfg_q) ? R_EXTRA : R_STOP;
                  else
                     bidx <= bidx + 1'b1;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            R_EXTRA: begin
               if (full_bit) begin
                  tcnt <= '0;
                  xbit <= rxs;
                  st   <= R_STOP;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            R_STOP: begin
               if (full_bit) begin
                  tcnt <= '0;
                  st   <= R_IDLE;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: st <= R_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_valid   <= 1'b0;
         rx_data    <= '0;
         rx_mpb     <= 1'b0;
         rx_par_err <= 1'b0;
         rx_frm_err <= 1'b0;
         rx_ovr_err <= 1'b0;
      end else if (done) begin
         rx_valid   <= 1'b1;
         rx_data    <= shreg;
         rx_mpb     <= cfg_q.mp_mode & xbit;
         rx_par_err <= !cfg_q.mp_mode && cfg_q.par_en && (((^shreg) ^ xbit) != cfg_q.par_odd);
         rx_frm_err <= !rxs;
         rx_ovr_err <= rx_valid && !rx_read;
      end else if (rx_read) begin
         rx_valid <= 1'b0;
      end
   end

   a_r11_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_read) |=> rx_valid);

   a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_valid && !rx_read) |=> rx_ovr_err);

   a_r7_marker_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cfg_q.mp_mode) |=> !rx_par_err);

   a_r8_start_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st == R_IDLE && tick && rxs) |=> (st == R_IDLE));

endmodule

// File: rtl/async_serial_xcvr.sv
module async_serial_xcvr
   import xcvr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   input  logic              cfg_mp_mode,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_mpb,
   output logic              txd,
   input  logic              rxd,
   output logic              rx_valid,
   input  logic              rx_read,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_mpb,
   output logic              rx_par_err,
   output logic              rx_frm_err,
   output logic              rx_ovr_err
);

   frame_cfg_t cfg;
   logic       rxs;

   assign cfg = '{par_en: cfg_par_en, par_odd: cfg_par_odd,
                  two_stop: cfg_two_stop, mp_mode: cfg_mp_mode};

   xcvr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs)
   );

   xcvr_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_mpb(tx_mpb), .txd(txd)
   );

   xcvr_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .rxs(rxs),
      .rx_read(rx_read), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_mpb(rx_mpb), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
      .rx_ovr_err(rx_ovr_err)
   );

   a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ready) |-> txd);

endmodule

// File: tb/async_serial_xcvr_test.sv
module async_serial_xcvr_test;

   localparam int CLK_PERIOD = 10;
   localparam int TICKDIV    = 4;
   localparam int BITCLK     = 16 * TICKDIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick;
   logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_mp_mode = 0;
   logic tx_valid = 0, tx_mpb = 0;
   logic [7:0] tx_data = 8'h00;
   logic tx_ready, txd, rxd, rx_valid, rx_mpb, rx_par_err, rx_frm_err, rx_ovr_err;
   logic rx_read = 0;
   logic [7:0] rx_data;
   logic loop = 1'b1;
   logic bench_rxd = 1'b1;
   logic auto_read = 1'b1;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   typedef struct packed {
      logic [7:0] d;
      logic       m;
      logic       p;
      logic       f;
   } exp_t;
   exp_t  sb_q[$];
   string sb_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [1:0] tdiv;
   always_ff @(posedge clk) begin
      if (!rst_n) tdiv <= '0;
      else        tdiv <= tdiv + 1'b1;
   end
   assign tick = rst_n && (tdiv == 2'(TICKDIV - 1));

   assign rxd = loop ? txd : bench_rxd;

   async_serial_xcvr uut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_two_stop(cfg_two_stop), .cfg_mp_mode(cfg_mp_mode),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_mpb(tx_mpb), .txd(txd), .rxd(rxd), .rx_valid(rx_valid),
      .rx_read(rx_read), .rx_data(rx_data), .rx_mpb(rx_mpb),
      .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_ovr_err(rx_ovr_err)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic push_exp(input [7:0] d, input m, input p, input f, input string tag);
      sb_q.push_back('{d: d, m: m, p: p, f: f});
      sb_tag.push_back(tag);
   endtask

   // scoreboard monitor: pops one expected item per delivered character
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && auto_read && rx_valid) begin
            if (sb_q.size() == 0) begin
               check(0, "R8", "unexpected character", int'(rx_data), 0);
            end else begin
               exp_t  e;
               string t;
               e = sb_q.pop_front();
               t = sb_tag.pop_front();
               check({rx_data, rx_mpb, rx_par_err, rx_frm_err, rx_ovr_err} ==
                     {e.d, e.m, e.p, e.f, 1'b0}, t, "rx {data,mpb,par,frm,ovr}",
                     int'({rx_data, rx_mpb, rx_par_err, rx_frm_err, rx_ovr_err}),
                     int'({e.d, e.m, e.p, e.f, 1'b0}));
            end
            rx_read = 1'b1;
            @(negedge clk);
            rx_read = 1'b0;
         end
      end
   end

   // send a character through the transmitter, check line bits and busy time
   task automatic tx_frame(input [7:0] d, input mpb, input bit flip, input string tag);
      logic [11:0] expv;
      logic [11:0] got;
      int nb;
      int dur;
      bit extra;
      logic xb;
      extra = cfg_mp_mode || cfg_par_en;
      xb = cfg_mp_mode ? mpb : ($countones(d) % 2 == 1) ^ cfg_par_odd;
      expv = '1;
      expv[0] = 1'b0;
      for (int i = 0; i < 8; i++) expv[i+1] = d[i];
      if (extra) expv[9] = xb;
      nb = 10 + (extra ? 1 : 0) + (cfg_two_stop ? 1 : 0);
      push_exp(d, cfg_mp_mode ? mpb : 1'b0, 1'b0, 1'b0, tag);
      got = '1;
      dur = 0;
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_data = d;
      tx_mpb = mpb;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      fork
         begin
            repeat (32) @(negedge clk);
            for (int i = 0; i < nb; i++) begin
               got[i] = txd;
               repeat (BITCLK) @(negedge clk);
            end
         end
         begin
            while (!tx_ready) begin
               @(negedge clk);
               dur++;
            end
         end
         begin
            if (flip) begin
               repeat (100) @(negedge clk);
               cfg_par_en = 1'b1;
               cfg_two_stop = 1'b1;
               cfg_mp_mode = 1'b1;
            end
         end
      join
      check(got == expv, tag, "tx line bits", int'(got), int'(expv));
      check((dur >= nb * BITCLK - 6) && (dur <= nb * BITCLK + 6), tag,
            "tx busy clocks", dur, nb * BITCLK);
      repeat (2 * BITCLK) @(negedge clk);
   endtask

   task automatic drive_bit(input logic b, input int clocks);
      bench_rxd = b;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic drive_char(input [7:0] d, input bit extra, input logic xb, input logic stop1);
      drive_bit(1'b0, BITCLK);
      for (int i = 0; i < 8; i++) drive_bit(d[i], BITCLK);
      if (extra) drive_bit(xb, BITCLK);
      if (stop1) drive_bit(1'b1, BITCLK);
      else begin
         drive_bit(1'b0, 44);
         drive_bit(1'b1, BITCLK - 44);
      end
   endtask

   task automatic set_cfg(input pe, input po, input ts, input mp);
      cfg_par_en = pe;
      cfg_par_odd = po;
      cfg_two_stop = ts;
      cfg_mp_mode = mp;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
      check(tx_ready == 1'b1, "R1", "tx_ready after reset", int'(tx_ready), 1);
      check(rx_valid == 1'b0, "R1", "rx_valid after reset", int'(rx_valid), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      // loopback: plain frames
      set_cfg(0, 0, 0, 0);
      tx_frame(8'hA5, 1'b0, 0, "R2");
      tx_frame(8'h3C, 1'b0, 0, "R2");
      // parity both senses
      set_cfg(1, 0, 0, 0);
      tx_frame(8'h07, 1'b0, 0, "R3");
      set_cfg(1, 1, 0, 0);
      tx_frame(8'h07, 1'b0, 0, "R3");
      tx_frame(8'hF0, 1'b0, 0, "R4");
      // two stop bits
      set_cfg(0, 0, 1, 0);
      tx_frame(8'h81, 1'b0, 0, "R5");
      // marker mode overriding odd parity
      set_cfg(1, 1, 0, 1);
      tx_frame(8'h55, 1'b1, 0, "R7");
      tx_frame(8'h01, 1'b0, 0, "R7");
      // mode flip mid-character
      set_cfg(0, 0, 0, 0);
      tx_frame(8'h6E, 1'b0, 1, "R10");
      set_cfg(0, 0, 0, 0);
      repeat (BITCLK) @(negedge clk);

      // bench-driven receive
      loop = 1'b0;
      repeat (BITCLK) @(negedge clk);

      set_cfg(1, 0, 0, 0);
      push_exp(8'h01, 0, 1, 0, "R4");
      drive_char(8'h01, 1, 1'b0, 1'b1);
      drive_bit(1'b1, 2 * BITCLK);
      push_exp(8'h01, 0, 0, 0, "R4");
      drive_char(8'h01, 1, 1'b1, 1'b1);
      drive_bit(1'b1, 2 * BITCLK);

      set_cfg(0, 0, 0, 0);
      push_exp(8'h96, 0, 0, 1, "R6");
      drive_char(8'h96, 0, 1'b0, 1'b0);
      drive_bit(1'b1, 2 * BITCLK);

      set_cfg(0, 0, 1, 0);
      push_exp(8'h5A, 0, 0, 0, "R6");
      push_exp(8'hC3, 0, 0, 0, "R6");
      drive_char(8'h5A, 0, 1'b0, 1'b1);
      drive_char(8'hC3, 0, 1'b0, 1'b1);
      drive_bit(1'b1, 2 * BITCLK);

      set_cfg(1, 0, 0, 1);
      push_exp(8'h01, 0, 0, 0, "R7");
      drive_char(8'h01, 1, 1'b0, 1'b1);
      drive_bit(1'b1, BITCLK);
      push_exp(8'h02, 1, 0, 0, "R7");
      drive_char(8'h02, 1, 1'b1, 1'b1);
      drive_bit(1'b1, 2 * BITCLK);

      set_cfg(0, 0, 0, 0);
      drive_bit(1'b0, 12);
      drive_bit(1'b1, 12 * BITCLK);
      check(rx_valid == 1'b0, "R8", "glitch gave a character", int'(rx_valid), 0);
      check(sb_q.size() == 0, "R8", "pending items after glitch", sb_q.size(), 0);

      // overrun with reads held off
      auto_read = 1'b0;
      drive_char(8'h11, 0, 1'b0, 1'b1);
      drive_bit(1'b1, BITCLK);
      check(rx_valid == 1'b1, "R11", "rx_valid held unread", int'(rx_valid), 1);
      check(rx_ovr_err == 1'b0, "R9", "no overrun on first", int'(rx_ovr_err), 0);
      drive_char(8'h22, 0, 1'b0, 1'b1);
      drive_bit(1'b1, BITCLK);
      check(rx_ovr_err == 1'b1, "R9", "overrun flag", int'(rx_ovr_err), 1);
      check(rx_data == 8'h22, "R9", "newest data kept", int'(rx_data), 8'h22);
      rx_read = 1'b1;
      @(negedge clk);
      rx_read = 1'b0;
      @(negedge clk);
      check(rx_valid == 1'b0, "R11", "rx_valid after read", int'(rx_valid), 0);
      auto_read = 1'b1;

      repeat (BITCLK) @(negedge clk);
      check(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule